// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator

This block gathers 64 interrupt sources into one request line toward a processor. The sources form two banks of 32 lines, called high and low. Each bank has three registers: a pending set, an enable mask, and a clear port where writing a 1 clears a bit. Software reaches all three through a single-cycle 32-bit register bus that decodes a 256-byte window.

A rising edge on a source line marks its bit as pending. The bit stays pending while the line stays high. It drops when the line falls or when software clears it. The processor request is high whenever some pending bit is also enabled in its bank. A status read returns only the bits that are both pending and enabled.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: On synchronous reset, every pending bit and both enable masks are zero. `cpu_irq` is low and `reg_rdata` is zero.
- R2: A source line seen high after being low at the previous clock edge sets its pending bit at that edge.
- R3: A pending bit clears at the first clock edge where its source line is sampled low.
- R4: A write to offset 0x14 (high bank) or 0x24 (low bank) loads that bank's enable mask. The mask can be read back at the same offset.
- R5: A read of offset 0x10 (high bank) or 0x20 (low bank) returns that bank's pending bits ANDed with its enable mask. Bit n always stands for source line n.
- R6: A write to offset 0x18 (high bank) or 0x28 (low bank) clears each pending bit whose data bit is 1 and leaves the other bits unchanged. A cleared bit stays clear while its source stays high, until the source rises again.
- R7: When a rising edge and a clear write hit the same bit in the same cycle, the bit ends up pending.
- R8: `cpu_irq` is high exactly when (high pending AND high enable) OR (low pending AND low enable) is nonzero. It follows any register change with no added delay.
- R9: `reg_rdata` shows the read value in the cycle after `reg_re` is high. It holds that value until the next read. A read in the same cycle as a write returns the state before the write.
- R10: Reads of 0x18, 0x28, 0x2c and every unmapped or unaligned offset return zero. Writes to the status offsets, to 0x2c, or to unmapped offsets change no state.
- R11: Register accesses to one bank never change the other bank's pending bits or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_src_lo | input | 32 | Low-bank source lines |
| irq_src_hi | input | 32 | High-bank source lines |
| reg_addr | input | 8 | Byte offset inside the register window |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| cpu_irq | output | 1 | Combined interrupt request to the processor |

## Verification
The hardest case to reach is the same-cycle collision of a clear write with a fresh rising edge on the same line. A related case is a line that stays high after being cleared and must not set its bit again. Directed steps place the rising edge on the exact cycle that carries the clear strobe. They also hold other lines high across a clear and then toggle them. A long pseudo-random phase mixes bank accesses, unmapped offsets and source toggles. A behavioural model is compared with the outputs on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_HI_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_HI_MASK = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_HI_CLR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_LO_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_LO_MASK = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_LO_CLR  = 8'h28;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_HI_STAT,
        RSEL_HI_MASK,
        RSEL_LO_STAT,
        RSEL_LO_MASK
    } rsel_e;

    typedef struct packed {
        logic  hi_mask_we;
        logic  hi_clr_we;
        logic  lo_mask_we;
        logic  lo_clr_we;
        rsel_e rsel;
    } dec_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    output dec_t              dec
);
    always_comb begin
        dec = '0;
        dec.rsel = RSEL_NONE;
        if (we) begin
            dec.hi_mask_we = (addr == OFF_HI_MASK);
            dec.hi_clr_we  = (addr == OFF_HI_CLR);
            dec.lo_mask_we = (addr == OFF_LO_MASK);
            dec.lo_clr_we  = (addr == OFF_LO_CLR);
        end
        if (re) begin
            case (addr)
                OFF_HI_STAT: dec.rsel = RSEL_HI_STAT;
                OFF_HI_MASK: dec.rsel = RSEL_HI_MASK;
                OFF_LO_STAT: dec.rsel = RSEL_LO_STAT;
                OFF_LO_MASK: dec.rsel = RSEL_LO_MASK;
                default:     dec.rsel = RSEL_NONE;
            endcase
        end
    end

    always_comb begin
        assert ($countones({dec.hi_mask_we, dec.hi_clr_we, dec.lo_mask_we, dec.lo_clr_we}) <= 1)
            else $error("AST_ONE_WRITE_TARGET"); // R11
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] status_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [W-1:0] src;
        logic [W-1:0] pend;
        logic [W-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_bits;

    always_comb begin
        bank_d   = bank_q;
        rise     = src & ~bank_q.src;
        clr_bits = clr_we ? wdata : '0;
        bank_d.src  = src;
        bank_d.pend = rise | (bank_q.pend & src & ~clr_bits);
        if (mask_we) begin
            bank_d.mask = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o   = bank_q.mask;
    assign status_o = bank_q.pend & bank_q.mask;
    assign hit_o    = |status_o;

    AST_PEND_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (bank_q.pend & ~bank_q.src) == '0); // R3

    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> bank_q.mask == $past(wdata)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> (bank_q.pend & $past(wdata) & ~($past(src) & ~$past(bank_q.src))) == '0); // R6

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (|(src & ~bank_q.src)) |=> (bank_q.pend & $past(src & ~bank_q.src)) == $past(src & ~bank_q.src)); // R7
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int LINES = BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  irq_src_lo,
    input  logic [LINES-1:0]  irq_src_hi,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic              cpu_irq
);
    localparam int NBANK = 2;

    typedef struct packed {
        logic [LINES-1:0] rdata;
    } top_t;

    top_t top_d, top_q;
    dec_t dec;

    logic [NBANK-1:0][LINES-1:0] srcs, masks, stats;
    logic [NBANK-1:0]            mask_wes, clr_wes, hits;

    irqc_decode i_decode (
        .addr (reg_addr),
        .we   (reg_we),
        .re   (reg_re),
        .dec  (dec)
    );

    assign srcs[0]     = irq_src_lo;
    assign srcs[1]     = irq_src_hi;
    assign mask_wes[0] = dec.lo_mask_we;
    assign mask_wes[1] = dec.hi_mask_we;
    assign clr_wes[0]  = dec.lo_clr_we;
    assign clr_wes[1]  = dec.hi_clr_we;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        irqc_bank #(.W(LINES)) i_bank (
            .clk      (clk),
            .rst      (rst),
            .src      (srcs[g]),
            .mask_we  (mask_wes[g]),
            .clr_we   (clr_wes[g]),
            .wdata    (reg_wdata),
            .mask_o   (masks[g]),
            .status_o (stats[g]),
            .hit_o    (hits[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (reg_re) begin
            case (dec.rsel)
                RSEL_HI_STAT: top_d.rdata = stats[1];
                RSEL_HI_MASK: top_d.rdata = masks[1];
                RSEL_LO_STAT: top_d.rdata = stats[0];
                RSEL_LO_MASK: top_d.rdata = masks[0];
                default:      top_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign reg_rdata = top_q.rdata;
    assign cpu_irq   = |hits;

    AST_IRQ_QUIET_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !cpu_irq && reg_rdata == '0); // R1

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata)); // R9

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_re && dec.rsel == RSEL_NONE) |=> reg_rdata == '0); // R10
endmodule

// File: tb/test_dual_bank_irq_ctrl.sv
module test_dual_bank_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_lo = '0, src_hi = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    dual_bank_irq_ctrl i_dual_bank_irq_ctrl (
        .clk(clk), .rst(rst), .irq_src_lo(src_lo), .irq_src_hi(src_hi),
        .reg_addr(addr), .reg_we(we), .reg_re(re), .reg_wdata(wdata),
        .reg_rdata(rdata), .cpu_irq(irq)
    );

    // behavioural reference
    logic [31:0] m_pl, m_ph, m_el, m_eh, m_sl, m_sh, m_rd;

    function automatic logic [31:0] next_pend(logic [31:0] p, logic [31:0] s,
                                              logic [31:0] sq, logic clr, logic [31:0] d);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) begin
            if (s[b] && !sq[b])      r[b] = 1'b1;
            else if (!s[b])          r[b] = 1'b0;
            else if (clr && d[b])    r[b] = 1'b0;
            else                     r[b] = p[b];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pl = '0; m_ph = '0; m_el = '0; m_eh = '0;
            m_sl = '0; m_sh = '0; m_rd = '0;
        end else begin
            logic [31:0] npl, nph;
            if (re) begin
                if (addr == 8'h10)      m_rd = m_ph & m_eh;
                else if (addr == 8'h14) m_rd = m_eh;
                else if (addr == 8'h20) m_rd = m_pl & m_el;
                else if (addr == 8'h24) m_rd = m_el;
                else                    m_rd = 0;
            end
            npl = next_pend(m_pl, src_lo, m_sl, we && addr == 8'h28, wdata);
            nph = next_pend(m_ph, src_hi, m_sh, we && addr == 8'h18, wdata);
            if (we && addr == 8'h24) m_el = wdata;
            if (we && addr == 8'h14) m_eh = wdata;
            m_pl = npl; m_ph = nph; m_sl = src_lo; m_sh = src_hi;
        end
    end

    always @(negedge clk) begin
        logic exp_irq;
        exp_irq = |((m_pl & m_el) | (m_ph & m_eh));
        vectors++;
        if (irq !== exp_irq || rdata !== m_rd) begin
            fails++;
            $display("FAIL %s: irq=%0b rdata=%08h expected irq=%0b rdata=%08h",
                     phase, irq, rdata, exp_irq, m_rd);
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr = 32'h1234_5679;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 rdata", rdata, 0);
        rd(8'h14, v); chk("R1 hi mask", v, 0);

        phase = "R4";
        wr(8'h14, 32'hA5A5_0001);
        rd(8'h14, v); chk("R4 hi mask", v, 32'hA5A5_0001);
        phase = "R11";
        rd(8'h24, v); chk("R11 lo mask untouched", v, 0);

        phase = "R2";
        @(negedge clk); src_hi = 32'h0000_0003;
        @(negedge clk);
        chk("R2 irq", {31'b0, irq}, 1);
        phase = "R5";
        rd(8'h10, v); chk("R5 hi status masked", v, 32'h0000_0001);

        phase = "R6";
        wr(8'h18, 32'h0000_0001);
        chk("R6 irq dropped", {31'b0, irq}, 0);
        wr(8'h14, 32'h3);
        rd(8'h10, v); chk("R6 bit0 stays clear, bit1 kept", v, 32'h2);

        phase = "R3";
        @(negedge clk); src_hi = 32'h0;
        @(negedge clk);
        rd(8'h10, v); chk("R3 dropped on deassert", v, 0);

        phase = "R7";
        @(negedge clk);
        src_hi = 32'h1; addr = 8'h18; wdata = 32'h1; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(8'h10, v); chk("R7 set wins", v, 32'h1);

        phase = "R8";
        wr(8'h14, 32'h0);
        chk("R8 hi masked off", {31'b0, irq}, 0);
        @(negedge clk); src_lo = 32'h8000_0000;
        wr(8'h24, 32'h8000_0000);
        chk("R8 lo raises irq", {31'b0, irq}, 1);

        phase = "R9";
        @(negedge clk); addr = 8'h24; re = 1'b1; we = 1'b1; wdata = 32'h0;
        @(negedge clk); re = 1'b0; we = 1'b0;
        chk("R9 read sees pre-write", rdata, 32'h8000_0000);
        repeat (3) @(negedge clk);
        chk("R9 hold", rdata, 32'h8000_0000);

        phase = "R10";
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h20, 32'h0); wr(8'h2c, 32'hFFFF_FFFF); wr(8'h25, 32'h0); wr(8'h80, 32'h0);
        rd(8'h24, v); chk("R10 writes ignored", v, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R10 clr read zero", v, 0);
        rd(8'h2c, v); chk("R10 2c read zero", v, 0);
        rd(8'h21, v); chk("R10 unaligned zero", v, 0);

        phase = "R5 random";
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] offs [10];
            offs = '{8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h2c, 8'h00, 8'h11, 8'hfc};
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            addr  = offs[lfsr[7:4] % 10];
            we    = lfsr[8];
            re    = lfsr[9];
            wdata = {lfsr[15:0], lfsr[31:16]};
            if (lfsr[10]) src_lo = src_lo ^ (32'h1 << lfsr[15:11]);
            if (lfsr[16]) src_hi = src_hi ^ (32'h1 << lfsr[21:17]);
        end
        @(negedge clk); we = 1'b0; re = 1'b0;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule